// File: doc/BRIEF.md
# Two-Level Trigger Event Buffer

This block stores strip hit snapshots from a front end and delivers them later on request. Each first-level accept copies the 256-bit hit vector into an event RAM. The write address is a free-running 8-bit event counter, and the counter value becomes the event's tag. Readout is requested later, at times that need not match the accepts. A request names an event tag and arrives on one of two streams: ordinary second-level requests or urgent regional requests. Each stream queues its tags in its own small FIFO, so bursts of requests are smoothed before service.

A controller state machine serves the queues one request at a time. It has three states. In `ST_IDLE` the arbiter samples the queues. The transition *grant* leaves `ST_IDLE` when either queue holds a tag and the downstream stop input is low; a regional tag always wins. In `ST_FETCH` the granted tag addresses the RAM. The transition *load* moves to `ST_SHIFT`, where the formatter for the request's type has built a fixed 268-bit packet. In `ST_SHIFT` the packet is shifted out MSB first. *Stall* keeps the controller in `ST_SHIFT` while the stop input is high. The transition *done* returns to `ST_IDLE` after the last bit.

Top module: `trig_event_buffer`

## Requirements
- R1: After reset, `ser_busy`, `ser_out`, `l1_ovf` and `r3_ovf` are 0, and `next_l0_id` is 0.
- R2: On a clock edge with `l0_accept` high, `l0_hits` is written into the RAM at address `next_l0_id`. `next_l0_id` then increments by one and wraps from 255 to 0. Without an accept it holds.
- R3: Each request stream has its own 8-deep FIFO of event tags. Within one stream, requests are served in arrival order.
- R4: When the arbiter samples and both FIFOs are non-empty, the regional request is served first.
- R5: A packet is 268 bits sent MSB first: a 4-bit type code (4'b0100 for second-level, 4'b0010 for regional), then the 8-bit tag, then the 256 hit bits stored at that tag, from bit 255 down to bit 0.
- R6: `ser_busy` is high from the first packet bit to the last, which is 268 cycles when no stall occurs. `ser_out` is 0 whenever `ser_busy` is low.
- R7: While `ser_busy` and `xoff` are both high, `ser_out` holds its value and no bit is lost. Serialisation resumes with the next bit when `xoff` falls.
- R8: The arbiter grants only while idle with `xoff` low. While `xoff` stays high in idle, queued requests wait and no packet starts.
- R9: A request that arrives while its FIFO already holds 8 tags is dropped, and that stream's overflow flag is set. The flag stays set until reset.
- R10: A request queued into an idle block with `xoff` low makes `ser_busy` rise on the second clock edge after the edge that queued it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l0_accept | input | 1 | First-level accept: store `l0_hits` this cycle |
| l0_hits | input | 256 | Hit vector at the pipeline output |
| next_l0_id | output | 8 | Tag the next accepted event will receive |
| l1_req | input | 1 | Second-level request strobe |
| l1_req_id | input | 8 | Tag requested by `l1_req` |
| r3_req | input | 1 | Regional request strobe |
| r3_req_id | input | 8 | Tag requested by `r3_req` |
| xoff | input | 1 | Downstream stop: stall output and hold off grants |
| ser_out | output | 1 | Serial packet data, MSB first |
| ser_busy | output | 1 | High while a packet is on `ser_out` |
| l1_ovf | output | 1 | Sticky: a second-level request was dropped |
| r3_ovf | output | 1 | Sticky: a regional request was dropped |

## Verification
Two functions can meet in one cycle: a second-level request and a regional request can be queued on the same edge, and both then reach the arbiter at its single sampling point. The bench provokes this by holding `xoff` high, strobing both request streams on one edge, adding a further second-level request, and then releasing `xoff`. The result is judged by the type code and tag of each packet in turn. The regional packet must come first, followed by the two second-level packets in the order they arrived.

// File: rtl/trigbuf_pkg.sv
package trigbuf_pkg;
    localparam int HIT_W  = 256;
    localparam int ID_W   = 8;
    localparam int TYPE_W = 4;
    localparam int Q_DEPTH = 8;
    localparam logic [TYPE_W-1:0] CODE_L1 = 4'b0100;
    localparam logic [TYPE_W-1:0] CODE_R3 = 4'b0010;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_t;
endpackage

// File: rtl/req_fifo.sv
module req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (!do_push && do_pop)
                count <= count - 1'b1;
            if (push && full)
                ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/event_ram.sv
module event_ram #(
    parameter int W  = 256,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [W-1:0] store [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/pkt_formatter.sv
module pkt_formatter #(
    parameter int          TYPE_W = 4,
    parameter int          ID_W   = 8,
    parameter int          HIT_W  = 256,
    parameter logic [TYPE_W-1:0] CODE = '0
) (
    input  logic [ID_W-1:0]                 tag,
    input  logic [HIT_W-1:0]                hits,
    output logic [TYPE_W+ID_W+HIT_W-1:0]    pkt
);
    assign pkt = {CODE, tag, hits};
endmodule

// File: rtl/trig_event_buffer.sv
module trig_event_buffer
    import trigbuf_pkg::*;
#(
    parameter int HW = HIT_W,
    parameter int IW = ID_W,
    parameter int QD = Q_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l0_accept,
    input  logic [HW-1:0] l0_hits,
    output logic [IW-1:0] next_l0_id,
    input  logic          l1_req,
    input  logic [IW-1:0] l1_req_id,
    input  logic          r3_req,
    input  logic [IW-1:0] r3_req_id,
    input  logic          xoff,
    output logic          ser_out,
    output logic          ser_busy,
    output logic          l1_ovf,
    output logic          r3_ovf
);
    localparam int PKT_W = TYPE_W + IW + HW;
    localparam int BC_W  = $clog2(PKT_W);
    localparam int NSTR  = 2;

    rd_state_t       state_q, state_d;
    logic            sel_r3_q, sel_r3_d;
    logic [IW-1:0]   tag_q, tag_d;
    logic [PKT_W-1:0] shreg_q;
    logic [BC_W-1:0] bitcnt_q;
    logic [IW-1:0]   id_cnt_q;

    logic [NSTR-1:0]  q_push, q_pop, q_empty, q_ovf;
    logic [IW-1:0]    q_in   [NSTR];
    logic [IW-1:0]    q_head [NSTR];
    logic [PKT_W-1:0] fmt_pkt [NSTR];

    logic           ram_re;
    logic [IW-1:0]  ram_raddr;
    logic [HW-1:0]  ram_rdata;
    logic           l1_empty, r3_empty;

    // stream 0: second-level, stream 1: regional
    assign q_push[0] = l1_req;
    assign q_in[0]   = l1_req_id;
    assign q_push[1] = r3_req;
    assign q_in[1]   = r3_req_id;

    generate
        for (genvar s = 0; s < NSTR; s++) begin : g_stream
            localparam logic [TYPE_W-1:0] SCODE = (s == 1) ? CODE_R3 : CODE_L1;
            req_fifo #(.W(IW), .DEPTH(QD)) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push[s]),
                .push_data (q_in[s]),
                .pop       (q_pop[s]),
                .head      (q_head[s]),
                .empty     (q_empty[s]),
                .ovf       (q_ovf[s])
            );
            pkt_formatter #(.TYPE_W(TYPE_W), .ID_W(IW), .HIT_W(HW), .CODE(SCODE)) u_fmt (
                .tag  (tag_q),
                .hits (ram_rdata),
                .pkt  (fmt_pkt[s])
            );
        end
    endgenerate

    assign l1_empty = q_empty[0];
    assign r3_empty = q_empty[1];
    assign l1_ovf   = q_ovf[0];
    assign r3_ovf   = q_ovf[1];

    event_ram #(.W(HW), .AW(IW)) u_ram (
        .clk   (clk),
        .we    (l0_accept),
        .waddr (id_cnt_q),
        .wdata (l0_hits),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sel_r3_q <= 1'b0;
            tag_q    <= '0;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            id_cnt_q <= '0;
        end else begin
            state_q  <= state_d;
            sel_r3_q <= sel_r3_d;
            tag_q    <= tag_d;
            if (l0_accept)
                id_cnt_q <= id_cnt_q + 1'b1;
            unique case (state_q)
                ST_FETCH: begin
                    shreg_q  <= sel_r3_q ? fmt_pkt[1] : fmt_pkt[0];
                    bitcnt_q <= '0;
                end
                ST_SHIFT: begin
                    if (!xoff) begin
                        shreg_q  <= {shreg_q[PKT_W-2:0], 1'b0};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // next state and controls
    always_comb begin
        state_d   = state_q;
        sel_r3_d  = sel_r3_q;
        tag_d     = tag_q;
        q_pop     = '0;
        ram_re    = 1'b0;
        ram_raddr = r3_empty ? q_head[0] : q_head[1];
        unique case (state_q)
            ST_IDLE: begin
                if (!xoff && (!r3_empty || !l1_empty)) begin      // grant
                    sel_r3_d = !r3_empty;
                    q_pop[1] = !r3_empty;
                    q_pop[0] = r3_empty;
                    ram_re   = 1'b1;
                    tag_d    = ram_raddr;
                    state_d  = ST_FETCH;
                end
            end
            ST_FETCH: state_d = ST_SHIFT;                           // load
            ST_SHIFT: begin
                if (!xoff && bitcnt_q == BC_W'(PKT_W - 1))
                    state_d = ST_IDLE;                              // done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ser_busy   = (state_q == ST_SHIFT);
    assign ser_out    = ser_busy & shreg_q[PKT_W-1];
    assign next_l0_id = id_cnt_q;
endmodule

// File: rtl/trigbuf_chk.sv
module trigbuf_chk
    import trigbuf_pkg::*;
#(
    parameter int IW = ID_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l0_accept,
    input logic [IW-1:0] next_l0_id,
    input logic          xoff,
    input logic          ser_out,
    input logic          ser_busy,
    input logic          l1_ovf,
    input logic          r3_ovf,
    input logic          l1_empty,
    input logic          r3_empty,
    input rd_state_t     state,
    input logic          sel_r3
);
    // R2
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l0_accept |=> next_l0_id == IW'($past(next_l0_id) + 1'b1));
    // R2
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l0_accept |=> $stable(next_l0_id));
    // R4
    r3_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !xoff && !r3_empty && !l1_empty) |=> (state == ST_FETCH && sel_r3));
    // R6
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_busy |-> !ser_out);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_busy && xoff) |=> (ser_busy && $stable(ser_out)));
    // R8
    no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && xoff) |=> state == ST_IDLE);
    // R9
    l1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l1_ovf |=> l1_ovf);
    // R9
    r3_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r3_ovf |=> r3_ovf);
endmodule

bind trig_event_buffer trigbuf_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .l0_accept  (l0_accept),
    .next_l0_id (next_l0_id),
    .xoff       (xoff),
    .ser_out    (ser_out),
    .ser_busy   (ser_busy),
    .l1_ovf     (l1_ovf),
    .r3_ovf     (r3_ovf),
    .l1_empty   (l1_empty),
    .r3_empty   (r3_empty),
    .state      (state_q),
    .sel_r3     (sel_r3_q)
);

// File: tb/trig_event_buffer_tb.sv
module trig_event_buffer_tb;
    localparam int HW = 256;
    localparam int IW = 8;
    localparam int PW = 268;
    localparam int NV = 6;
    // {is_r3, tag, stall_at, stall_len}
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 8'd5,   9'd300, 4'd0},
        {1'b1, 8'd3,   9'd300, 4'd0},
        {1'b0, 8'd255, 9'd0,   4'd3},
        {1'b1, 8'd128, 9'd267, 4'd5},
        {1'b0, 8'd0,   9'd11,  4'd2},
        {1'b1, 8'd200, 9'd100, 4'd15}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l0_accept = 1'b0;
    logic [HW-1:0] l0_hits = '0;
    logic [IW-1:0] next_l0_id;
    logic          l1_req = 1'b0, r3_req = 1'b0;
    logic [IW-1:0] l1_req_id = '0, r3_req_id = '0;
    logic          xoff = 1'b0;
    logic          ser_out, ser_busy, l1_ovf, r3_ovf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [HW-1:0] exp_mem [256];

    always #2.5 clk = ~clk;

    trig_event_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .l0_accept(l0_accept), .l0_hits(l0_hits),
        .next_l0_id(next_l0_id), .l1_req(l1_req), .l1_req_id(l1_req_id),
        .r3_req(r3_req), .r3_req_id(r3_req_id), .xoff(xoff),
        .ser_out(ser_out), .ser_busy(ser_busy), .l1_ovf(l1_ovf), .r3_ovf(r3_ovf)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [HW-1:0] gen_hits(input int n);
        logic [HW-1:0] v;
        for (int k = 0; k < 8; k++)
            v[k*32 +: 32] = (n * 32'h9E3779B9) ^ (k * 32'h85EBCA6B) ^ 32'h5A5A0F0F;
        return v;
    endfunction

    function automatic logic [PW-1:0] exp_pkt(input bit is_r3, input logic [IW-1:0] tag);
        return {(is_r3 ? 4'b0010 : 4'b0100), tag, exp_mem[tag]};
    endfunction

    task automatic send_req(input bit is_r3, input logic [IW-1:0] tag);
        @(negedge clk);
        if (is_r3) begin r3_req = 1'b1; r3_req_id = tag; end
        else       begin l1_req = 1'b1; l1_req_id = tag; end
        @(negedge clk);
        r3_req = 1'b0; l1_req = 1'b0;
    endtask

    // collects one packet; caller is at a negedge; xoff is driven here
    task automatic get_pkt(input int stall_at, input int stall_len, output logic [PW-1:0] pkt);
        int guard = 0;
        int idx = 0;
        int stalled = 0;
        pkt = '0;
        xoff = 1'b0;
        while (!ser_busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        check(ser_busy, "R6 packet start", PW'(ser_busy), PW'(1));
        while (idx < PW) begin
            if (!ser_busy) begin
                check(1'b0, "R6 busy dropped mid-packet", PW'(idx), PW'(PW));
                idx = PW;
            end else begin
                pkt[PW-1-idx] = ser_out;
                if (idx == stall_at && stalled < stall_len) begin
                    xoff = 1'b1;
                    stalled++;
                end else begin
                    xoff = 1'b0;
                    idx++;
                end
                @(negedge clk);
            end
        end
        xoff = 1'b0;
    endtask

    initial begin
        logic [PW-1:0] got;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(ser_busy == 1'b0 && ser_out == 1'b0, "R1 idle outputs", PW'({ser_busy, ser_out}), PW'(0));
        check(l1_ovf == 1'b0 && r3_ovf == 1'b0, "R1 flags clear", PW'({l1_ovf, r3_ovf}), PW'(0));
        check(next_l0_id == 8'd0, "R1 tag counter", PW'(next_l0_id), PW'(0));

        // R2 store 260 events, wrapping the tag counter
        for (int n = 0; n < 260; n++) begin
            l0_accept = 1'b1;
            l0_hits = gen_hits(n);
            exp_mem[n % 256] = gen_hits(n);
            @(negedge clk);
        end
        l0_accept = 1'b0;
        check(next_l0_id == 8'd4, "R2 tag wrap", PW'(next_l0_id), PW'(4));
        @(negedge clk);
        check(next_l0_id == 8'd4, "R2 tag holds", PW'(next_l0_id), PW'(4));

        // R5 R6 R7 vector walk
        for (int v = 0; v < NV; v++) begin
            send_req(VEC[v][21], VEC[v][20:13]);
            get_pkt(int'(VEC[v][12:4]), int'(VEC[v][3:0]), got);
            check(got == exp_pkt(VEC[v][21], VEC[v][20:13]), "R5/R7 packet content", got, exp_pkt(VEC[v][21], VEC[v][20:13]));
            check(!ser_busy && !ser_out, "R6 busy ends after last bit", PW'({ser_busy, ser_out}), PW'(0));
        end

        // R10 latency
        @(negedge clk);
        l1_req = 1'b1; l1_req_id = 8'd42;
        @(negedge clk);
        l1_req = 1'b0;
        check(!ser_busy, "R10 busy low after queue edge", PW'(ser_busy), PW'(0));
        @(negedge clk);
        check(!ser_busy, "R10 busy low after grant edge", PW'(ser_busy), PW'(0));
        @(negedge clk);
        check(ser_busy, "R10 busy high after load edge", PW'(ser_busy), PW'(1));
        get_pkt(300, 0, got);
        check(got == exp_pkt(1'b0, 8'd42), "R10 packet", got, exp_pkt(1'b0, 8'd42));

        // R4 R8 simultaneous requests under xoff
        @(negedge clk);
        xoff = 1'b1;
        l1_req = 1'b1; l1_req_id = 8'd10;
        r3_req = 1'b1; r3_req_id = 8'd20;
        @(negedge clk);
        r3_req = 1'b0; l1_req_id = 8'd11;
        @(negedge clk);
        l1_req = 1'b0;
        for (int w = 0; w < 6; w++) begin
            @(negedge clk);
            check(!ser_busy, "R8 no grant while xoff", PW'(ser_busy), PW'(0));
        end
        get_pkt(300, 0, got);
        check(got == exp_pkt(1'b1, 8'd20), "R4 regional first", got, exp_pkt(1'b1, 8'd20));
        get_pkt(300, 0, got);
        check(got == exp_pkt(1'b0, 8'd10), "R3 second-level order 1", got, exp_pkt(1'b0, 8'd10));
        get_pkt(300, 0, got);
        check(got == exp_pkt(1'b0, 8'd11), "R3 second-level order 2", got, exp_pkt(1'b0, 8'd11));

        // R9 overflow of the second-level queue
        @(negedge clk);
        xoff = 1'b1;
        for (int q = 0; q < 9; q++) begin
            l1_req = 1'b1; l1_req_id = 8'(q + 60);
            @(negedge clk);
        end
        l1_req = 1'b0;
        @(negedge clk);
        check(l1_ovf && !r3_ovf, "R9 overflow flag", PW'({l1_ovf, r3_ovf}), PW'(2));
        for (int q = 0; q < 8; q++) begin
            get_pkt(300, 0, got);
            check(got == exp_pkt(1'b0, 8'(q + 60)), "R3/R9 queued tags", got, exp_pkt(1'b0, 8'(q + 60)));
        end
        for (int w = 0; w < 10; w++) begin
            @(negedge clk);
            check(!ser_busy, "R9 dropped request not served", PW'(ser_busy), PW'(0));
        end
        check(l1_ovf, "R9 flag sticky", PW'(l1_ovf), PW'(1));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!l1_ovf && !r3_ovf, "R9 flag cleared by reset", PW'({l1_ovf, r3_ovf}), PW'(0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule